// File: doc/BRIEF.md
# Host Transmit FIFO Write Port

This block is the host-facing entry point of a transmit FIFO. A host writes either a 16-bit word or a single byte per write strobe, and two byte enables select which half of the bus carries data. Every accepted byte lands in one byte-wide store entry, tagged with an end-of-frame bit. When the host marks the final write of a frame, that tag goes on the last byte of the write. A configuration input sets which half of a full word leaves the store first, so that byte order follows the layout of the host's memory.

The `xfer_req` output tells the host that at least a threshold of free space (`REQ_THRESH`, 16 bytes by default) is available. It is only a hint. The host may keep writing after it falls, and writes are refused only when the store lacks room for the bytes in the write. Each accepted write is acknowledged one cycle later. The `frame_cnt` output gives the number of complete frames held, which is the number of tagged bytes still in the store.

The drain side is a valid/ready byte stream with a last-byte flag. `out_valid` is high whenever the store is not empty. A byte is consumed on a clock edge where both `out_valid` and `out_ready` are high. While `out_ready` is low, the presented byte and its flag do not change.

Top module: `tx_host_wport`

## Requirements
- R1: After reset, `host_ack` and `out_valid` are 0, `frame_cnt` is 0 and `xfer_req` is 1.
- R2: A write with `host_be` = 2'b11 stores two bytes. With `byte_swap` = 0, bits [7:0] leave first and bits [15:8] second. With `byte_swap` = 1 the order is reversed.
- R3: A write with `host_be` = 2'b01 stores one byte from bits [7:0]. A write with 2'b10 stores one byte from bits [15:8]. A write with 2'b00 stores nothing and is not acknowledged.
- R4: A write that is accepted raises `host_ack` for exactly the following cycle. `host_ack` is high in no other cycle.
- R5: A write is refused when the free space, measured before the write's clock edge, is smaller than the number of bytes it carries. A refused write stores nothing and gets no acknowledge. A word write with one byte free is refused as a whole.
- R6: `xfer_req` is 1 exactly when the free space is at least `REQ_THRESH`. Writes that fit are still accepted while `xfer_req` is 0.
- R7: A read strobe (`host_rd`) without a write gets no acknowledge and leaves the store unchanged.
- R8: `host_eof` sets `out_last` on the final byte of the write it accompanies, and on no other byte of that write.
- R9: `out_valid` is 1 exactly when the store holds a byte. Bytes leave in the order they were written. While `out_ready` is 0, `out_data` and `out_last` hold.
- R10: `frame_cnt` equals the number of stored bytes that carry the end-of-frame tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Write strobe for the FIFO data port |
| host_rd | input | 1 | Read strobe on the FIFO data port (has no effect) |
| host_be | input | 2 | Byte enables: bit 0 = bits [7:0], bit 1 = bits [15:8] |
| host_wdata | input | 16 | Write data |
| host_eof | input | 1 | Marks the final write of a frame |
| byte_swap | input | 1 | Selects which byte of a word leaves first |
| host_ack | output | 1 | Data-valid acknowledge, the cycle after an accepted write |
| xfer_req | output | 1 | Free space is at least REQ_THRESH |
| frame_cnt | output | $clog2(DEPTH)+1 | Complete frames held |
| out_valid | output | 1 | Drain stream has a byte |
| out_ready | input | 1 | Drain side takes the byte |
| out_data | output | 8 | Drained byte |
| out_last | output | 1 | Drained byte ends a frame |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any traffic, and that the host may assert `host_rd` and `host_wr` freely. They do not assume the host honours `xfer_req`. The stimulus deliberately keeps writing past the point where the request falls and into a full store, with the drain stalled for long stretches, so that the refusal and hold-stable properties are exercised. Random byte enables include 2'b00, and read strobes are mixed in with writes.

// File: rtl/tx_fifo_pkg.sv
package tx_fifo_pkg;
  typedef struct packed {
    logic       last;
    logic [7:0] data;
  } fifo_ent_t;
endpackage

// File: rtl/tx_lane_steer.sv
module tx_lane_steer
  import tx_fifo_pkg::*;
(
  input  logic        wr,
  input  logic [1:0]  be,
  input  logic [15:0] wdata,
  input  logic        eof,
  input  logic        swap,
  output logic [1:0]  nbytes,
  output fifo_ent_t   ent0,
  output fifo_ent_t   ent1
);
  always_comb begin
    nbytes = 2'd0;
    ent0   = '0;
    ent1   = '0;
    if (wr) begin
      unique case (be)
        2'b11: begin
          nbytes     = 2'd2;
          ent0.data  = swap ? wdata[15:8] : wdata[7:0];
          ent1.data  = swap ? wdata[7:0]  : wdata[15:8];
          ent1.last  = eof;
        end
        2'b01: begin
          nbytes = 2'd1;
          ent0   = '{last: eof, data: wdata[7:0]};
        end
        2'b10: begin
          nbytes = 2'd1;
          ent0   = '{last: eof, data: wdata[15:8]};
        end
        default: nbytes = 2'd0;
      endcase
    end
  end
endmodule

// File: rtl/tx_byte_store.sv
module tx_byte_store
  import tx_fifo_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               push_n,
  input  fifo_ent_t                ent0,
  input  fifo_ent_t                ent1,
  input  logic                     pop,
  output fifo_ent_t                head,
  output logic [$clog2(DEPTH):0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  fifo_ent_t      mem [DEPTH];
  logic [AW-1:0]  wp_q, rp_q;
  logic [CW-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (push_n != 2'd0) mem[wp_q] <= ent0;
    if (push_n == 2'd2) mem[wp_q + AW'(1)] <= ent1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_q + AW'(push_n);
      rp_q  <= rp_q + AW'(pop);
      cnt_q <= cnt_q + CW'(push_n) - CW'(pop);
    end
  end

  assign head  = mem[rp_q];
  assign count = cnt_q;

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0 && !pop) |=> $stable(head));
endmodule

// File: rtl/tx_frame_counter.sv
module tx_frame_counter #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         dec,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (inc && !dec) cnt <= cnt + W'(1);
    else if (dec && !inc) cnt <= cnt - W'(1);
  end
endmodule

// File: rtl/tx_host_wport.sv
module tx_host_wport
  import tx_fifo_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int REQ_THRESH = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    host_wr,
  input  logic                    host_rd,
  input  logic [1:0]              host_be,
  input  logic [15:0]             host_wdata,
  input  logic                    host_eof,
  input  logic                    byte_swap,
  output logic                    host_ack,
  output logic                    xfer_req,
  output logic [$clog2(DEPTH):0]  frame_cnt,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [7:0]              out_data,
  output logic                    out_last
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] DEPTH_C  = CW'(DEPTH);
  localparam logic [CW-1:0] THRESH_C = CW'(REQ_THRESH);

  logic [1:0]    nbytes, push_n;
  fifo_ent_t     ent0, ent1, head;
  logic [CW-1:0] count, free_sp;
  logic          accept, pop, tag_in;

  tx_lane_steer i_steer (
    .wr(host_wr), .be(host_be), .wdata(host_wdata), .eof(host_eof),
    .swap(byte_swap), .nbytes(nbytes), .ent0(ent0), .ent1(ent1)
  );

  assign free_sp = DEPTH_C - count;
  assign accept  = (nbytes != 2'd0) && (CW'(nbytes) <= free_sp);
  assign push_n  = accept ? nbytes : 2'd0;
  assign pop     = out_valid && out_ready;
  assign tag_in  = accept && host_eof;

  tx_byte_store #(.DEPTH(DEPTH)) i_store (
    .clk(clk), .rst_n(rst_n), .push_n(push_n), .ent0(ent0), .ent1(ent1),
    .pop(pop), .head(head), .count(count)
  );

  tx_frame_counter #(.W(CW)) i_frames (
    .clk(clk), .rst_n(rst_n), .inc(tag_in), .dec(pop && head.last),
    .cnt(frame_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) host_ack <= 1'b0;
    else        host_ack <= accept;
  end

  assign xfer_req  = free_sp >= THRESH_C;
  assign out_valid = count != '0;
  assign out_data  = head.data;
  assign out_last  = head.last;

  // R5
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == DEPTH_C && host_wr) |=> !host_ack);

  // R4
  ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> $past(host_wr));

  // R7
  read_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr) |=> !host_ack);

  // R3
  no_lane_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_be == 2'b00) |=> !host_ack);

  // R10
  empty_no_frames_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> frame_cnt == '0);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last));
endmodule

// File: tb/test_tx_host_wport.sv
module test_tx_host_wport;
  localparam int DEPTH = 64;
  localparam int THR   = 16;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic host_wr, host_rd, host_eof, byte_swap, out_ready;
  logic [1:0]  host_be;
  logic [15:0] host_wdata;
  logic host_ack, xfer_req, out_valid, out_last;
  logic [CW-1:0] frame_cnt;
  logic [7:0] out_data;

  always #10 clk = ~clk;

  tx_host_wport #(.DEPTH(DEPTH), .REQ_THRESH(THR)) i_tx_host_wport (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_be(host_be), .host_wdata(host_wdata), .host_eof(host_eof),
    .byte_swap(byte_swap), .host_ack(host_ack), .xfer_req(xfer_req),
    .frame_cnt(frame_cnt), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  int vectors = 0;
  int fails   = 0;
  logic [8:0] q[$];
  logic exp_ack = 1'b0;

  function automatic int tags();
    int n = 0;
    foreach (q[i]) if (q[i][8]) n++;
    return n;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compare();
    chk("R4 ack", int'(host_ack), int'(exp_ack));
    chk("R9 valid", int'(out_valid), int'(q.size() > 0));
    if (q.size() > 0) begin
      chk("R2/R3/R9 data", int'(out_data), int'(q[0][7:0]));
      chk("R8 last", int'(out_last), int'(q[0][8]));
    end
    chk("R6 req", int'(xfer_req), int'((DEPTH - q.size()) >= THR));
    chk("R10 frames", int'(frame_cnt), tags());
  endtask

  task automatic step(input logic wr, input logic rd, input logic [1:0] be,
                      input logic [15:0] d, input logic eof, input logic sw,
                      input logic rdy);
    int need;
    host_wr = wr; host_rd = rd; host_be = be; host_wdata = d;
    host_eof = eof; byte_swap = sw; out_ready = rdy;
    need = !wr ? 0 : (be == 2'b11) ? 2 : (be == 2'b00) ? 0 : 1;
    exp_ack = (need != 0) && (need <= DEPTH - q.size());
    if (rdy && q.size() > 0) void'(q.pop_front());
    if (exp_ack) begin
      if (need == 2) begin
        q.push_back({1'b0, sw ? d[15:8] : d[7:0]});
        q.push_back({eof,  sw ? d[7:0]  : d[15:8]});
      end else begin
        q.push_back({eof, be[0] ? d[7:0] : d[15:8]});
      end
    end
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; host_wr = 0; host_rd = 0; host_be = 0; host_wdata = 0;
    host_eof = 0; byte_swap = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 ack", int'(host_ack), 0);
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 frames", int'(frame_cnt), 0);
    chk("R1 req", int'(xfer_req), 1);

    // R2 word order, both swap settings
    step(1, 0, 2'b11, 16'hB2A1, 0, 0, 0);
    step(1, 0, 2'b11, 16'hD4C3, 1, 1, 0);
    // R3 byte lanes and empty enables
    step(1, 0, 2'b01, 16'h5566, 0, 0, 0);
    step(1, 0, 2'b10, 16'h7788, 1, 0, 0);
    step(1, 0, 2'b00, 16'h9999, 1, 0, 0);
    chk("R3 empty-enable no ack", int'(host_ack), 0);
    // R7 read strobe ignored
    step(0, 1, 2'b11, 16'h0000, 0, 0, 0);
    chk("R7 read no ack", int'(host_ack), 0);
    for (int i = 0; i < 12; i++) step(0, 0, 2'b00, 16'h0, 0, 0, 1);

    // R5/R6: fill with drain stalled, keep writing past req drop
    for (int i = 0; i < 34; i++)
      step(1, 0, 2'b11, 16'(i * 16'h0101 + 16'h0102), (i % 5) == 4, i[0], 0);
    chk("R5 full", int'(out_valid && !xfer_req), 1);
    step(1, 0, 2'b01, 16'h00EE, 0, 0, 0);
    chk("R5 byte refused when full", int'(host_ack), 0);
    step(0, 0, 2'b00, 16'h0, 0, 0, 1);
    step(1, 0, 2'b11, 16'hABCD, 1, 0, 0);
    chk("R5 word refused with one free", int'(host_ack), 0);
    step(1, 0, 2'b10, 16'hEF00, 1, 0, 0);
    chk("R5 byte fits last slot", int'(host_ack), 1);
    for (int i = 0; i < 70; i++) step(0, 0, 2'b00, 16'h0, 0, 0, 1);

    // random traffic with phases of slow and fast draining
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] r = $urandom;
      int pr = ((i / 500) % 2 == 0) ? 3 : 12;
      step(r[0] | r[1], r[2] & r[3], r[5:4], r[31:16], r[8:6] == 3'd0,
           r[9], (r[15:12] < 4'(pr)));
    end
    for (int i = 0; i < 80; i++) step(0, 0, 2'b00, 16'h0, 0, 0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule